// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the hazard-tracking core of a single-issue machine that feeds five functional units: one integer unit that also handles loads, two multipliers, one adder and one divider. Decoded instructions arrive one per cycle with an operation class, a destination register and two source registers. They leave the controller in program order, but each one starts reading its operands as soon as they are valid. Results are written back as soon as no older reader still needs the value being overwritten. There is no forwarding and no speculation.

For every unit the controller keeps a record: a busy flag, the operation class, the three register numbers, the producing unit for each source and a ready flag for each source. For each of the 32 registers it keeps the tag of the unit that will write it next. From these it raises a read-operands strobe for each unit, takes back a done pulse from each unit when execution ends, and grants one register-file write per cycle. It also drives the register-file read enables and the write port. The datapaths are outside the block; the controller only sequences them.

All decisions in a cycle use the state registered at the start of that cycle. A cleared source flag therefore takes effect one cycle after the write-back that clears it.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy and no register has a pending writer. `fu_start`, `fu_wr_grant`, `rf_we` and `rf_rd_mask` are all zero, and `in_ready` is high for any instruction.
- R2: The `in_op` value selects the unit as follows. 0 is a load and goes to the integer unit (bit 0 of the unit vectors). 1 is add or subtract and goes to the adder (bit 3). 3 is divide and goes to the divider (bit 4). 2 is multiply and goes to the first multiplier (bit 1) when that one is free, otherwise to the second (bit 2).
- R3: An instruction issues (`in_valid` and `in_ready` high at a rising edge) only if its selected unit is not busy. A unit stays busy through the cycle of its write grant, so the earliest next issue to it is the following cycle.
- R4: An instruction whose destination already has a pending writer keeps `in_ready` low until the cycle after that writer's grant. No later instruction can issue ahead of it.
- R5: A unit raises `fu_start` for one cycle, in the first cycle after issue in which both of its sources are ready. A source with a pending producer becomes ready in the cycle after that producer's grant. In the same cycle `rf_rd_mask` has a bit set for each source register being read. A load's source fields are not tracked: a load starts in the cycle after issue and sets no mask bits.
- R6: If an instruction issues in the same cycle that its source's producer is granted, that source counts as ready. The instruction starts in the next cycle.
- R7: A finished unit is not granted while any busy unit still has an unread ready source equal to the finished unit's destination.
- R8: A unit is eligible for a write grant from the cycle after its `fu_done` pulse. At most one grant is given per cycle, and the lowest unit index wins. With the grant, `rf_we` is high and `rf_waddr` carries that unit's destination.
- R9: Consider this six-instruction sequence, issued from cycle 1, with unit latencies of load 1, add 2, multiply 10 and divide 40: load F6; load F2; multiply F0=F2*F4; subtract F8=F6-F2; divide F10=F0/F6; add F6=F8+F2. It issues in cycles 1, 5, 6, 7, 8 and 13. It is granted writes in cycles 4, 8, 20, 12, 62 and 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 2 | Operation class (0 load, 1 add/sub, 2 multiply, 3 divide) |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_ready | output | 1 | Instruction can issue this cycle |
| fu_start | output | 5 | Per-unit read-operands strobe |
| fu_done | input | 5 | Per-unit execution-finished pulse |
| fu_wr_grant | output | 5 | Per-unit write-result grant, at most one high |
| rf_rd_mask | output | 32 | Register-file read enables for this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |

## Verification
The bench attacks the cycle where a write-back and a new issue touch the same register. A design that fails to treat that source as ready leaves the consumer waiting forever, and one that wakes too early reads before the write. It holds a later result behind an earlier unread source (the add writing F6 must wait until cycle 22). A design without that check writes at 17 and corrupts the divide's operand. Two units finish in the same cycle to show that the lower index wins and the other is granted the next cycle. A destination conflict and a full multiplier pair show that stalls hold back every younger instruction. A load whose source names a pending register must still start at once.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int NUM_FU  = 5;
    parameter int NUM_REG = 32;
    localparam int REG_W = $clog2(NUM_REG);
    localparam int TAG_W = $clog2(NUM_FU + 1);

    localparam int FU_INT   = 0;
    localparam int FU_MUL_A = 1;
    localparam int FU_MUL_B = 2;
    localparam int FU_ADD   = 3;
    localparam int FU_DIV   = 4;

    typedef enum logic [1:0] {
        OPC_LOAD = 2'd0,
        OPC_ADD  = 2'd1,
        OPC_MUL  = 2'd2,
        OPC_DIV  = 2'd3
    } opc_e;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [TAG_W-1:0] fu_tag_t;

    // per-unit status record; tag value 0 means "no producer"
    typedef struct packed {
        logic     busy;
        opc_e     op;
        reg_idx_t fi;
        reg_idx_t fj;
        reg_idx_t fk;
        fu_tag_t  qj;
        fu_tag_t  qk;
        logic     rj;
        logic     rk;
        logic     running;
        logic     finished;
    } fu_rec_t;

    typedef struct packed {
        fu_rec_t [NUM_FU-1:0]  fu;
        fu_tag_t [NUM_REG-1:0] rs;
    } sb_state_t;
endpackage

// File: rtl/sb_unit_select.sv
module sb_unit_select
    import sb_pkg::*;
(
    input  opc_e              op,
    input  logic [NUM_FU-1:0] busy,
    output logic [NUM_FU-1:0] pick,
    output logic              free
);
    always_comb begin
        pick = '0;
        case (op)
            OPC_LOAD: pick[FU_INT] = 1'b1;
            OPC_ADD:  pick[FU_ADD] = 1'b1;
            OPC_DIV:  pick[FU_DIV] = 1'b1;
            default: begin
                if (busy[FU_MUL_A] && !busy[FU_MUL_B]) begin
                    pick[FU_MUL_B] = 1'b1;
                end else begin
                    pick[FU_MUL_A] = 1'b1;
                end
            end
        endcase
        free = |(pick & ~busy);
    end
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
    parameter int N = 5,
    parameter int W = 5
) (
    input  logic [N-1:0]        pend_j,
    input  logic [N-1:0]        pend_k,
    input  logic [N-1:0][W-1:0] fi,
    input  logic [N-1:0][W-1:0] fj,
    input  logic [N-1:0][W-1:0] fk,
    output logic [N-1:0]        clear
);
    for (genvar u = 0; u < N; u++) begin : g_writer
        logic [N-1:0] blk;
        for (genvar f = 0; f < N; f++) begin : g_reader
            assign blk[f] = (pend_j[f] && (fj[f] == fi[u])) ||
                            (pend_k[f] && (fk[f] == fi[u]));
        end
        assign clear[u] = ~|blk;
    end
endmodule

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // isolate the lowest set bit
    assign gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic [REG_W-1:0]   in_dst,
    input  logic [REG_W-1:0]   in_src_a,
    input  logic [REG_W-1:0]   in_src_b,
    output logic               in_ready,
    output logic [NUM_FU-1:0]  fu_start,
    input  logic [NUM_FU-1:0]  fu_done,
    output logic [NUM_FU-1:0]  fu_wr_grant,
    output logic [NUM_REG-1:0] rf_rd_mask,
    output logic               rf_we,
    output logic [REG_W-1:0]   rf_waddr
);
    sb_state_t st_q, st_d;

    opc_e                   op_in;
    logic [NUM_FU-1:0]      busy_v, ready_v, elig_v, war_ok, sel_v;
    logic [NUM_FU-1:0]      pend_j, pend_k;
    logic [NUM_FU-1:0][REG_W-1:0] fi_v, fj_v, fk_v;
    logic                   sel_free, waw, fire;
    fu_tag_t                wtag, itag, qa, qb;
    reg_idx_t               wdst;
    fu_rec_t                new_rec;

    assign op_in = opc_e'(in_op);

    // per-unit views of the current records
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            busy_v[u]  = st_q.fu[u].busy;
            ready_v[u] = st_q.fu[u].busy && !st_q.fu[u].running &&
                         !st_q.fu[u].finished && st_q.fu[u].rj && st_q.fu[u].rk;
            pend_j[u]  = st_q.fu[u].busy && (st_q.fu[u].op != OPC_LOAD) && st_q.fu[u].rj;
            pend_k[u]  = st_q.fu[u].busy && (st_q.fu[u].op != OPC_LOAD) && st_q.fu[u].rk;
            fi_v[u]    = st_q.fu[u].fi;
            fj_v[u]    = st_q.fu[u].fj;
            fk_v[u]    = st_q.fu[u].fk;
            elig_v[u]  = st_q.fu[u].finished && war_ok[u];
        end
    end

    sb_unit_select u_sel (
        .op   (op_in),
        .busy (busy_v),
        .pick (sel_v),
        .free (sel_free)
    );

    sb_war_check #(.N(NUM_FU), .W(REG_W)) u_war (
        .pend_j (pend_j),
        .pend_k (pend_k),
        .fi     (fi_v),
        .fj     (fj_v),
        .fk     (fk_v),
        .clear  (war_ok)
    );

    sb_prio_pick #(.N(NUM_FU)) u_pick (
        .req (elig_v),
        .gnt (fu_wr_grant)
    );

    // write-back target, issue target and the issued record
    always_comb begin
        wtag = '0;
        wdst = '0;
        itag = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (fu_wr_grant[u]) begin
                wtag = fu_tag_t'(u + 1);
                wdst = st_q.fu[u].fi;
            end
            if (sel_v[u]) begin
                itag = fu_tag_t'(u + 1);
            end
        end
        waw      = st_q.rs[in_dst] != '0;
        in_ready = sel_free && !waw;
        fire     = in_valid && in_ready;

        qa = st_q.rs[in_src_a];
        qb = st_q.rs[in_src_b];
        // producer writing this very cycle: operand is valid next cycle
        if (rf_we && qa == wtag) qa = '0;
        if (rf_we && qb == wtag) qb = '0;
        if (op_in == OPC_LOAD) begin
            qa = '0;
            qb = '0;
        end
        new_rec          = '0;
        new_rec.busy     = 1'b1;
        new_rec.op       = op_in;
        new_rec.fi       = in_dst;
        new_rec.fj       = in_src_a;
        new_rec.fk       = in_src_b;
        new_rec.qj       = qa;
        new_rec.qk       = qb;
        new_rec.rj       = (qa == '0);
        new_rec.rk       = (qb == '0);
    end

    // register-file read enables for units starting this cycle
    always_comb begin
        rf_rd_mask = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (ready_v[u] && st_q.fu[u].op != OPC_LOAD) begin
                rf_rd_mask[st_q.fu[u].fj] = 1'b1;
                rf_rd_mask[st_q.fu[u].fk] = 1'b1;
            end
        end
    end

    assign fu_start = ready_v;
    assign rf_we    = |fu_wr_grant;
    assign rf_waddr = wdst;

    // next-state
    always_comb begin
        st_d = st_q;
        for (int u = 0; u < NUM_FU; u++) begin
            if (ready_v[u]) begin
                st_d.fu[u].rj      = 1'b0;
                st_d.fu[u].rk      = 1'b0;
                st_d.fu[u].running = 1'b1;
            end
            if (st_q.fu[u].running && fu_done[u]) begin
                st_d.fu[u].running  = 1'b0;
                st_d.fu[u].finished = 1'b1;
            end
            if (fu_wr_grant[u]) begin
                st_d.fu[u].busy     = 1'b0;
                st_d.fu[u].finished = 1'b0;
            end
            if (rf_we && st_q.fu[u].busy) begin
                if (st_q.fu[u].qj == wtag) begin
                    st_d.fu[u].qj = '0;
                    st_d.fu[u].rj = 1'b1;
                end
                if (st_q.fu[u].qk == wtag) begin
                    st_d.fu[u].qk = '0;
                    st_d.fu[u].rk = 1'b1;
                end
            end
        end
        if (rf_we) begin
            st_d.rs[wdst] = '0;
        end
        if (fire) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (sel_v[u]) begin
                    st_d.fu[u] = new_rec;
                end
            end
            st_d.rs[in_dst] = itag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] fu_start,
    input logic [N-1:0] fu_done,
    input logic [N-1:0] fu_wr_grant
);
    // 0 waiting/idle, 1 executing, 2 execution finished
    logic [N-1:0][1:0] phase_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            for (int u = 0; u < N; u++) begin
                if (fu_start[u]) begin
                    phase_q[u] <= 2'd1;
                end else if (phase_q[u] == 2'd1 && fu_done[u]) begin
                    phase_q[u] <= 2'd2;
                end else if (fu_wr_grant[u]) begin
                    phase_q[u] <= 2'd0;
                end
            end
        end
    end

    assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (fu_start == '0 && fu_wr_grant == '0));

    assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_wr_grant));

    for (genvar u = 0; u < N; u++) begin : g_unit
        assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fu_start[u] |-> phase_q[u] == 2'd0);
        assert_grant_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fu_wr_grant[u] |-> phase_q[u] == 2'd2);
        assert_grant_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fu_wr_grant[u] |=> !fu_wr_grant[u]);
    end
endmodule

bind sb_ctrl sb_ctrl_chk #(.N(sb_pkg::NUM_FU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fu_start    (fu_start),
    .fu_done     (fu_done),
    .fu_wr_grant (fu_wr_grant)
);

// File: tb/sb_ctrl_test.sv
`timescale 1ns/1ps
module sb_ctrl_test;
    import sb_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [1:0]         in_op = '0;
    logic [REG_W-1:0]   in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic               in_ready;
    logic [NUM_FU-1:0]  fu_start, fu_wr_grant;
    logic [NUM_FU-1:0]  fu_done = '0;
    logic [NUM_REG-1:0] rf_rd_mask;
    logic               rf_we;
    logic [REG_W-1:0]   rf_waddr;

    int checks = 0, errors = 0, cyc = 0, base = 0;
    int cnt [NUM_FU];
    int p_op [16], p_dst [16], p_a [16], p_b [16], p_at [16], iss [16];
    int s_cyc [64], s_unit [64], s_mask [64], sn = 0;
    int g_cyc [64], g_unit [64], g_addr [64], gn = 0;

    sb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_ready(in_ready), .fu_start(fu_start), .fu_done(fu_done),
        .fu_wr_grant(fu_wr_grant), .rf_rd_mask(rf_rd_mask),
        .rf_we(rf_we), .rf_waddr(rf_waddr)
    );

    initial forever #2.5 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    function automatic int lat_of(input int u);
        case (u)
            FU_INT: return 1;
            FU_ADD: return 2;
            FU_DIV: return 40;
            default: return 10;
        endcase
    endfunction

    // fixed-latency execution units
    initial begin
        for (int u = 0; u < NUM_FU; u++) cnt[u] = 0;
        forever begin
            @(negedge clk);
            for (int u = 0; u < NUM_FU; u++) begin
                fu_done[u] = 1'b0;
                if (cnt[u] != 0) begin
                    cnt[u]--;
                    if (cnt[u] == 0) fu_done[u] = 1'b1;
                end
                if (fu_start[u]) cnt[u] = lat_of(u);
            end
        end
    end

    // event log in cycles relative to the scenario start (first = 1)
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (fu_start[u] && sn < 64) begin
                    s_cyc[sn] = cyc - base + 1; s_unit[sn] = u; s_mask[sn] = int'(rf_rd_mask); sn++;
                end
                if (fu_wr_grant[u] && gn < 64) begin
                    g_cyc[gn] = cyc - base + 1; g_unit[gn] = u;
                    g_addr[gn] = rf_we ? int'(rf_waddr) : -1; gn++;
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_g(input int u, input int nth, input bit want_addr);
        int k = 0;
        for (int i = 0; i < gn; i++) begin
            if (g_unit[i] == u) begin
                if (k == nth) return want_addr ? g_addr[i] : g_cyc[i];
                k++;
            end
        end
        return -1;
    endfunction

    function automatic int find_s(input int u, input int nth, input bit want_mask);
        int k = 0;
        for (int i = 0; i < sn; i++) begin
            if (s_unit[i] == u) begin
                if (k == nth) return want_mask ? s_mask[i] : s_cyc[i];
                k++;
            end
        end
        return -1;
    endfunction

    task automatic set_ins(input int i, input int op, input int d, input int a, input int b, input int at);
        p_op[i] = op; p_dst[i] = d; p_a[i] = a; p_b[i] = b; p_at[i] = at; iss[i] = -1;
    endtask

    task automatic run_prog(input int n, input int drain);
        int i = 0;
        @(negedge clk);
        base = cyc; sn = 0; gn = 0;
        while (i < n) begin
            in_op    = p_op[i][1:0];
            in_dst   = p_dst[i][REG_W-1:0];
            in_src_a = p_a[i][REG_W-1:0];
            in_src_b = p_b[i][REG_W-1:0];
            in_valid = (cyc - base + 1) >= p_at[i];
            #1;
            if (in_valid && in_ready) begin
                iss[i] = cyc - base + 1;
                i++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (drain) @(negedge clk);
    endtask

    task automatic t_reset;
        in_op = 2'd0; in_dst = 5'd3;
        #1;
        chk("R1", "fu_start", int'(fu_start), 0);
        chk("R1", "fu_wr_grant", int'(fu_wr_grant), 0);
        chk("R1", "rf_we", int'(rf_we), 0);
        chk("R1", "rf_rd_mask", int'(rf_rd_mask), 0);
        chk("R1", "in_ready", int'(in_ready), 1);
    endtask

    task automatic t_reference;
        set_ins(0, 0, 6, 2, 0, 1);
        set_ins(1, 0, 2, 3, 0, 1);
        set_ins(2, 2, 0, 2, 4, 1);
        set_ins(3, 1, 8, 6, 2, 1);
        set_ins(4, 3, 10, 0, 6, 1);
        set_ins(5, 1, 6, 8, 2, 1);
        run_prog(6, 60);
        chk("R9", "issue ld1", iss[0], 1);
        chk("R9", "issue ld2", iss[1], 5);
        chk("R9", "issue mul", iss[2], 6);
        chk("R9", "issue sub", iss[3], 7);
        chk("R9", "issue div", iss[4], 8);
        chk("R9", "issue add", iss[5], 13);
        chk("R9", "write ld1", find_g(FU_INT, 0, 0), 4);
        chk("R8", "waddr ld1", find_g(FU_INT, 0, 1), 6);
        chk("R9", "write ld2", find_g(FU_INT, 1, 0), 8);
        chk("R9", "write sub", find_g(FU_ADD, 0, 0), 12);
        chk("R9", "write mul", find_g(FU_MUL_A, 0, 0), 20);
        chk("R2", "mul waddr on first multiplier", find_g(FU_MUL_A, 0, 1), 0);
        chk("R7", "write add held by divide read", find_g(FU_ADD, 1, 0), 22);
        chk("R8", "waddr add", find_g(FU_ADD, 1, 1), 6);
        chk("R9", "write div", find_g(FU_DIV, 0, 0), 62);
        chk("R2", "div waddr", find_g(FU_DIV, 0, 1), 10);
        chk("R5", "mul start after ld2 write", find_s(FU_MUL_A, 0, 0), 9);
        chk("R5", "read mask cycle 9", find_s(FU_MUL_A, 0, 1), 32'h54);
        chk("R5", "load start mask", find_s(FU_INT, 0, 1), 0);
        chk("R5", "div start after mul write", find_s(FU_DIV, 0, 0), 21);
        chk("R5", "add start", find_s(FU_ADD, 1, 0), 14);
    endtask

    task automatic t_waw;
        set_ins(0, 1, 4, 1, 3, 1);
        set_ins(1, 2, 4, 5, 6, 1);
        set_ins(2, 3, 7, 5, 6, 1);
        run_prog(3, 50);
        chk("R4", "add write", find_g(FU_ADD, 0, 0), 5);
        chk("R4", "mul issue after F4 write", iss[1], 6);
        chk("R4", "div held behind mul", iss[2], 7);
        chk("R4", "mul write", find_g(FU_MUL_A, 0, 0), 18);
    endtask

    task automatic t_struct;
        set_ins(0, 2, 1, 2, 3, 1);
        set_ins(1, 2, 4, 2, 3, 1);
        set_ins(2, 2, 5, 2, 3, 1);
        run_prog(3, 20);
        chk("R2", "second mul uses second multiplier", find_g(FU_MUL_B, 0, 0), 14);
        chk("R3", "third mul waits for free unit", iss[2], 14);
        chk("R3", "first multiplier write", find_g(FU_MUL_A, 0, 0), 13);
        chk("R3", "third mul write", find_g(FU_MUL_A, 1, 0), 26);
    endtask

    task automatic t_priority;
        set_ins(0, 1, 10, 1, 2, 1);
        set_ins(1, 0, 11, 1, 2, 1);
        run_prog(2, 10);
        chk("R8", "integer wins tie", find_g(FU_INT, 0, 0), 5);
        chk("R8", "integer waddr", find_g(FU_INT, 0, 1), 11);
        chk("R8", "adder next cycle", find_g(FU_ADD, 0, 0), 6);
    endtask

    task automatic t_bypass;
        set_ins(0, 0, 12, 1, 1, 1);
        set_ins(1, 1, 13, 12, 12, 4);
        set_ins(2, 0, 14, 13, 13, 5);
        run_prog(3, 12);
        chk("R6", "consumer issue on write cycle", iss[1], 4);
        chk("R6", "consumer start", find_s(FU_ADD, 0, 0), 5);
        chk("R5", "consumer read mask", find_s(FU_ADD, 0, 1), 32'h1000);
        chk("R5", "load ignores pending source", find_s(FU_INT, 1, 0), 6);
        chk("R8", "load write", find_g(FU_INT, 1, 0), 8);
        chk("R6", "consumer write", find_g(FU_ADD, 0, 0), 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reference();
        t_waw();
        t_struct();
        t_priority();
        t_bypass();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule